// File: doc/BRIEF.md
# Warp Register Value Cache

This block is a small, fully associative cache that sits in front of a large per-warp register file. When an instruction from an enabled warp produces a destination value, the value is kept in the cache under a tag made of the warp number and the register number. Later reads from enabled warps look in the cache first and get the value back in the same cycle. A cache miss tells the requester to read the main register file instead. A write to a register that is already cached overwrites that entry in place.

Entries are replaced in allocation order: the entry allocated earliest leaves first. When an entry is evicted, its value is sent on a valid/ready writeback stream to the main register file. The exception is an entry whose value has been marked as no longer needed, which is dropped. A read can carry a last-use flag; if that read hits, the entry is marked dead.

Warps are enabled and disabled with plain one-cycle control pulses. Only enabled warps may use the cache. A write from a disabled warp is passed straight to the writeback stream. Disabling a warp drains all of its entries, oldest first and one per cycle. Live values go out through the writeback stream and dead ones are dropped. While this drain runs, the write port is held off.

Back-pressure rules:
- On the write port, a transfer happens when `wr_valid` and `wr_ready` are both high.
- `wr_ready` may depend on the presented warp and register. The source must not wait for `wr_ready` before raising `wr_valid`.
- On the writeback stream, `wb_valid` and its payload stay unchanged until `wb_ready` is seen high.

Top module: `rfc_cache`

## Requirements
- R1: After reset the cache holds no entries, no warp is enabled, `rd_hit` is low for every read, `wb_valid` is low, and a write is accepted (it is bypassed).
- R2: An accepted write from an enabled warp whose tag is not cached allocates an entry. From the next cycle, a read with the same warp and register returns `rd_hit`=1 and that data combinationally, in the cycle the read is presented.
- R3: An accepted write whose warp and register match a cached entry replaces that entry's data and clears its dead mark, without allocating.
- R4: With all 8 entries occupied, a write that misses evicts the entry allocated earliest. The freed slot takes the new value. A live victim appears on the writeback stream on the next cycle with its warp, register and data.
- R5: A read with `rd_last`=1 that hits marks the entry dead. A dead victim is discarded with no writeback, and its eviction never waits on the writeback stream.
- R6: A disabled warp never hits on reads. Its accepted writes appear unchanged on the writeback stream on the next cycle.
- R7: A pulse on `deact_valid` disables the warp and removes all of its entries, one per cycle in allocation order. Live entries are written back and dead entries are discarded. `wr_ready` is low in the pulse cycle and while any removal is pending.
- R8: While `wb_valid`=1 and `wb_ready`=0, the writeback payload holds. A write that needs the writeback stream (bypass or live eviction) sees `wr_ready`=0 until the stream can accept.
- R9: Enable and disable pulses take effect from the next cycle. If both name the same warp in one cycle, the warp ends up disabled.
- R10: If a last-use read and a write hit the same entry in the same cycle, the write wins: the entry holds the new data and stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Enable pulse for `act_warp` |
| act_warp | input | 4 | Warp to enable |
| deact_valid | input | 1 | Disable-and-drain pulse for `deact_warp` |
| deact_warp | input | 4 | Warp to disable |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with `wr_valid` |
| wr_warp | input | 4 | Warp of the written register |
| wr_reg | input | 6 | Register number written |
| wr_data | input | 1024 | 32 lanes of 32-bit value |
| rd_valid | input | 1 | Read lookup valid |
| rd_last | input | 1 | Read is the last use of the value |
| rd_warp | input | 4 | Warp of the read register |
| rd_reg | input | 6 | Register number read |
| rd_hit | output | 1 | Lookup found a live entry |
| rd_data | output | 1024 | Data of the hitting entry |
| wb_valid | output | 1 | Writeback payload valid |
| wb_ready | input | 1 | Main register file accepts the writeback |
| wb_warp | output | 4 | Warp of the written-back value |
| wb_reg | output | 6 | Register of the written-back value |
| wb_data | output | 1024 | Written-back value |

## Verification
Two functions can land on the same entry in one cycle. In one case, a last-use read marks an entry dead while a write either overwrites that entry or evicts it. In the other, a drain step competes with a stalled writeback stream. The bench provokes the first case by presenting a last-use read and a hitting write for the same tag together, and by presenting a last-use read together with a write that evicts the read entry. It provokes the second by disabling warps while `wb_ready` toggles. A behavioural model decides the result each cycle from the entry's state before the edge: a dead mark set in that cycle does not cancel a writeback already chosen, and a write hit leaves the entry live. Random traffic over a few warps and registers then creates many more such collisions, and every cycle is compared against the model.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  // What an accepted write does to the cache
  typedef enum logic [2:0] {
    WA_NONE,
    WA_BYPASS,   // disabled warp: straight to writeback stream
    WA_UPDATE,   // tag present: overwrite in place
    WA_ALLOC,    // tag absent, free slot available
    WA_EVICT     // tag absent, cache full: replace oldest
  } wr_act_e;
endpackage

// File: rtl/rfc_first.sv
module rfc_first #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rfc_match.sv
module rfc_match #(
  parameter int N  = 8,
  parameter int KW = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*KW-1:0] keys,
  input  logic [N-1:0]    mask,
  input  logic [KW-1:0]   key,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = mask[g] && (keys[g*KW +: KW] == key);
  end

  rfc_first #(.W(N)) u_pick (
    .req   (eq),
    .found (hit),
    .idx   (idx)
  );
endmodule

// File: rtl/rfc_cache.sv
module rfc_cache
  import rfc_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int N_WARPS = 16,
  parameter int N_REGS  = 64,
  parameter int LANES   = 32,
  parameter int LANE_W  = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 act_valid,
  input  logic [$clog2(N_WARPS)-1:0]           act_warp,
  input  logic                                 deact_valid,
  input  logic [$clog2(N_WARPS)-1:0]           deact_warp,
  input  logic                                 wr_valid,
  output logic                                 wr_ready,
  input  logic [$clog2(N_WARPS)-1:0]           wr_warp,
  input  logic [$clog2(N_REGS)-1:0]            wr_reg,
  input  logic [LANES*LANE_W-1:0]              wr_data,
  input  logic                                 rd_valid,
  input  logic                                 rd_last,
  input  logic [$clog2(N_WARPS)-1:0]           rd_warp,
  input  logic [$clog2(N_REGS)-1:0]            rd_reg,
  output logic                                 rd_hit,
  output logic [LANES*LANE_W-1:0]              rd_data,
  output logic                                 wb_valid,
  input  logic                                 wb_ready,
  output logic [$clog2(N_WARPS)-1:0]           wb_warp,
  output logic [$clog2(N_REGS)-1:0]            wb_reg,
  output logic [LANES*LANE_W-1:0]              wb_data
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WID_W  = $clog2(N_WARPS);
  localparam int RID_W  = $clog2(N_REGS);
  localparam int KEY_W  = WID_W + RID_W;
  localparam int IDX_W  = $clog2(N_ENT);
  localparam logic [IDX_W-1:0] ORD_LAST = IDX_W'(N_ENT - 1);

  // entry state
  logic [N_ENT-1:0]  valid_q, dead_q, flush_q;
  logic [KEY_W-1:0]  key_q  [N_ENT];
  logic [IDX_W-1:0]  ord_q  [N_ENT];   // 0 = oldest allocation
  logic [DATA_W-1:0] data_q [N_ENT];
  logic [N_WARPS-1:0] active_q, active_d;

  // writeback output stage
  logic              wb_valid_q;
  logic [WID_W-1:0]  wb_warp_q;
  logic [RID_W-1:0]  wb_reg_q;
  logic [DATA_W-1:0] wb_data_q;

  logic [N_ENT*KEY_W-1:0] key_flat;
  logic [N_ENT*IDX_W-1:0] ord_flat;
  logic [N_ENT-1:0]       live;

  for (genvar g = 0; g < N_ENT; g++) begin : g_flat
    assign key_flat[g*KEY_W +: KEY_W] = key_q[g];
    assign ord_flat[g*IDX_W +: IDX_W] = ord_q[g];
  end
  assign live = valid_q & ~flush_q;

  // read lookup
  logic             rd_match;
  logic [IDX_W-1:0] rd_idx;
  rfc_match #(.N(N_ENT), .KW(KEY_W)) u_rd_match (
    .keys (key_flat), .mask (live), .key ({rd_warp, rd_reg}),
    .hit  (rd_match), .idx (rd_idx)
  );
  assign rd_hit  = rd_valid && active_q[rd_warp] && rd_match;
  assign rd_data = data_q[rd_idx];

  // write lookup
  logic             wr_match;
  logic [IDX_W-1:0] wr_idx;
  rfc_match #(.N(N_ENT), .KW(KEY_W)) u_wr_match (
    .keys (key_flat), .mask (live), .key ({wr_warp, wr_reg}),
    .hit  (wr_match), .idx (wr_idx)
  );

  // free slot
  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  rfc_first #(.W(N_ENT)) u_free (
    .req (~valid_q), .found (has_free), .idx (free_idx)
  );

  // replacement victim: entry of age rank zero
  logic             victim_found;
  logic [IDX_W-1:0] victim_idx;
  rfc_match #(.N(N_ENT), .KW(IDX_W)) u_victim (
    .keys (ord_flat), .mask (valid_q), .key ('0),
    .hit  (victim_found), .idx (victim_idx)
  );

  // drain target: oldest entry flagged for removal
  logic [N_ENT-1:0] flag_by_ord;
  always_comb begin
    flag_by_ord = '0;
    for (int o = 0; o < N_ENT; o++)
      for (int i = 0; i < N_ENT; i++)
        if (flush_q[i] && ord_q[i] == IDX_W'(o)) flag_by_ord[o] = 1'b1;
  end

  logic             fl_any, fl_found;
  logic [IDX_W-1:0] fl_ord, fl_idx;
  rfc_first #(.W(N_ENT)) u_fl_ord (
    .req (flag_by_ord), .found (fl_any), .idx (fl_ord)
  );
  rfc_match #(.N(N_ENT), .KW(IDX_W)) u_fl_match (
    .keys (ord_flat), .mask (flush_q), .key (fl_ord),
    .hit  (fl_found), .idx (fl_idx)
  );

  logic wb_free, fl_go, fl_wb;
  assign wb_free = !wb_valid_q || wb_ready;
  assign fl_go   = fl_any && fl_found && (dead_q[fl_idx] || wb_free);
  assign fl_wb   = fl_go && !dead_q[fl_idx];

  // write decision
  wr_act_e wr_act;
  logic    wr_can, wr_fire;
  always_comb begin
    wr_act = WA_NONE;
    wr_can = 1'b0;
    if (!active_q[wr_warp]) begin
      wr_act = WA_BYPASS;
      wr_can = wb_free;
    end else if (wr_match) begin
      wr_act = WA_UPDATE;
      wr_can = 1'b1;
    end else if (has_free) begin
      wr_act = WA_ALLOC;
      wr_can = 1'b1;
    end else begin
      wr_act = WA_EVICT;
      wr_can = victim_found && (dead_q[victim_idx] || wb_free);
    end
  end
  assign wr_ready = !(|flush_q) && !deact_valid && wr_can;
  assign wr_fire  = wr_valid && wr_ready;

  logic             ev_wb;
  logic [IDX_W-1:0] nvalid;
  assign ev_wb  = wr_fire && wr_act == WA_EVICT && !dead_q[victim_idx];
  assign nvalid = IDX_W'($countones(valid_q));

  // warp enable map
  always_comb begin
    active_d = active_q;
    if (act_valid)   active_d[act_warp]   = 1'b1;
    if (deact_valid) active_d[deact_warp] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

  // entry control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dead_q  <= '0;
      flush_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        key_q[i] <= '0;
        ord_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (rd_hit && rd_last && rd_idx == IDX_W'(i)) dead_q[i] <= 1'b1;
        if (deact_valid && valid_q[i] && key_q[i][KEY_W-1 -: WID_W] == deact_warp)
          flush_q[i] <= 1'b1;
        if (fl_go && valid_q[i] && ord_q[i] > ord_q[fl_idx])
          ord_q[i] <= ord_q[i] - 1'b1;
        if (wr_fire && wr_act == WA_EVICT && valid_q[i])
          ord_q[i] <= ord_q[i] - 1'b1;
        if (wr_fire && wr_act == WA_UPDATE && wr_idx == IDX_W'(i))
          dead_q[i] <= 1'b0;
        if (wr_fire && wr_act == WA_ALLOC && free_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          key_q[i]   <= {wr_warp, wr_reg};
          dead_q[i]  <= 1'b0;
          flush_q[i] <= 1'b0;
          ord_q[i]   <= nvalid;
        end
        if (wr_fire && wr_act == WA_EVICT && victim_idx == IDX_W'(i)) begin
          key_q[i]   <= {wr_warp, wr_reg};
          dead_q[i]  <= 1'b0;
          flush_q[i] <= 1'b0;
          ord_q[i]   <= ORD_LAST;
        end
        if (fl_go && fl_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
          dead_q[i]  <= 1'b0;
          flush_q[i] <= 1'b0;
        end
      end
    end
  end

  // entry data, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      if (wr_fire && ((wr_act == WA_UPDATE && wr_idx == IDX_W'(i)) ||
                      (wr_act == WA_ALLOC  && free_idx == IDX_W'(i)) ||
                      (wr_act == WA_EVICT  && victim_idx == IDX_W'(i))))
        data_q[i] <= wr_data;
    end
  end

  // writeback stage source select
  logic              wb_load;
  logic [KEY_W-1:0]  wb_key_n;
  logic [DATA_W-1:0] wb_data_n;
  always_comb begin
    wb_load   = 1'b1;
    wb_key_n  = {wr_warp, wr_reg};
    wb_data_n = wr_data;
    if (fl_wb) begin
      wb_key_n  = key_q[fl_idx];
      wb_data_n = data_q[fl_idx];
    end else if (wr_fire && wr_act == WA_BYPASS) begin
      wb_key_n  = {wr_warp, wr_reg};
      wb_data_n = wr_data;
    end else if (ev_wb) begin
      wb_key_n  = key_q[victim_idx];
      wb_data_n = data_q[victim_idx];
    end else begin
      wb_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      wb_warp_q  <= '0;
      wb_reg_q   <= '0;
    end else if (wb_load) begin
      wb_valid_q <= 1'b1;
      {wb_warp_q, wb_reg_q} <= wb_key_n;
    end else if (wb_ready) begin
      wb_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_load) wb_data_q <= wb_data_n;
  end

  assign wb_valid = wb_valid_q;
  assign wb_warp  = wb_warp_q;
  assign wb_reg   = wb_reg_q;
  assign wb_data  = wb_data_q;
endmodule

module rfc_cache_chk #(
  parameter int N_ENT  = 8,
  parameter int WID_W  = 4,
  parameter int RID_W  = 6,
  parameter int DATA_W = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              deact_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_hit,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [WID_W-1:0]  wb_warp,
  input logic [RID_W-1:0]  wb_reg,
  input logic [DATA_W-1:0] wb_data,
  input logic [N_ENT-1:0]  valid_q,
  input logic [N_ENT-1:0]  flush_q
);
  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_warp) && $stable(wb_reg) && $stable(wb_data));

  // R7
  deact_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> !wr_ready);

  // R7
  drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_q) |-> !wr_ready);

  // R6
  hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_valid);

  // R4
  occ_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|$past(flush_q)) |-> $countones(valid_q) >= $countones($past(valid_q)));
endmodule

bind rfc_cache rfc_cache_chk #(
  .N_ENT (N_ENT),
  .WID_W ($clog2(N_WARPS)),
  .RID_W ($clog2(N_REGS)),
  .DATA_W(LANES * LANE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .deact_valid(deact_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_hit     (rd_hit),
  .wb_valid   (wb_valid),
  .wb_ready   (wb_ready),
  .wb_warp    (wb_warp),
  .wb_reg     (wb_reg),
  .wb_data    (wb_data),
  .valid_q    (valid_q),
  .flush_q    (flush_q)
);

// File: tb/sim_rfc_cache.sv
`timescale 1ns/1ps
module sim_rfc_cache;
  localparam int DW    = 1024;
  localparam int NE    = 8;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic act_valid = 0, deact_valid = 0, wr_valid = 0, rd_valid = 0, rd_last = 0, wb_ready = 1;
  logic [3:0] act_warp = 0, deact_warp = 0, wr_warp = 0, rd_warp = 0;
  logic [5:0] wr_reg = 0, rd_reg = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_hit, wb_valid;
  logic [DW-1:0] rd_data, wb_data;
  logic [3:0] wb_warp;
  logic [5:0] wb_reg;

  rfc_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .act_valid(act_valid), .act_warp(act_warp),
    .deact_valid(deact_valid), .deact_warp(deact_warp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_warp(wr_warp), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_warp(rd_warp), .rd_reg(rd_reg),
    .rd_hit(rd_hit), .rd_data(rd_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  // behavioural reference: queue in allocation order, index 0 oldest
  typedef struct {
    int w; int r; logic [DW-1:0] d; bit dead; bit fl;
  } ent_t;
  ent_t q[$];
  bit   en[16];
  bit   mwv; int mww; int mwr; logic [DW-1:0] mwd;

  bit e_hit, e_ready, wbfree;
  logic [DW-1:0] e_rdata;
  int rd_qi, wi, kind;  // kind: 1 bypass 2 update 3 alloc 4 evict

  int nchk = 0, nfail = 0;
  string cur = "R1";
  bit done = 0;

  task automatic chk(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s got %h exp %h", cur, what, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(int unsigned s);
    logic [DW-1:0] d;
    for (int l = 0; l < 32; l++) d[l*32 +: 32] = s ^ (l * 32'h01010101);
    return d;
  endfunction

  task automatic model_comb();
    bit anyfl, can;
    e_hit = 0; e_rdata = '0; rd_qi = -1; wi = -1; anyfl = 0;
    wbfree = !mwv || wb_ready;
    foreach (q[k]) begin
      if (q[k].fl) anyfl = 1;
      if (!q[k].fl && q[k].w == int'(rd_warp) && q[k].r == int'(rd_reg)) rd_qi = k;
      if (!q[k].fl && q[k].w == int'(wr_warp) && q[k].r == int'(wr_reg)) wi = k;
    end
    if (rd_valid && en[rd_warp] && rd_qi >= 0) begin
      e_hit = 1; e_rdata = q[rd_qi].d;
    end
    if (!en[wr_warp])      begin kind = 1; can = wbfree; end
    else if (wi >= 0)      begin kind = 2; can = 1; end
    else if (q.size() < NE) begin kind = 3; can = 1; end
    else                   begin kind = 4; can = q[0].dead || wbfree; end
    e_ready = !anyfl && !deact_valid && can;
  endtask

  task automatic model_seq();
    int fi; bit fgo, fire;
    ent_t n;
    fi = -1;
    foreach (q[k]) if (q[k].fl && fi < 0) fi = k;
    fgo  = (fi >= 0) && (q[fi].dead || wbfree);
    fire = wr_valid && e_ready;
    if (fgo && !q[fi].dead) begin
      mwv = 1; mww = q[fi].w; mwr = q[fi].r; mwd = q[fi].d;
    end else if (fire && kind == 1) begin
      mwv = 1; mww = wr_warp; mwr = wr_reg; mwd = wr_data;
    end else if (fire && kind == 4 && !q[0].dead) begin
      mwv = 1; mww = q[0].w; mwr = q[0].r; mwd = q[0].d;
    end else if (wb_ready) mwv = 0;
    if (rd_valid && rd_last && e_hit) q[rd_qi].dead = 1;
    if (deact_valid) foreach (q[k]) if (q[k].w == int'(deact_warp)) q[k].fl = 1;
    if (fgo) q.delete(fi);
    if (fire) begin
      n.w = wr_warp; n.r = wr_reg; n.d = wr_data; n.dead = 0; n.fl = 0;
      if (kind == 2) begin q[wi].d = wr_data; q[wi].dead = 0; end
      else if (kind == 3) q.push_back(n);
      else if (kind == 4) begin void'(q.pop_front()); q.push_back(n); end
    end
    if (act_valid)   en[act_warp]   = 1;
    if (deact_valid) en[deact_warp] = 0;
  endtask

  task automatic cyc();
    #1;
    model_comb();
    chk("wr_ready", DW'(wr_ready), DW'(e_ready));
    chk("rd_hit",   DW'(rd_hit),   DW'(e_hit));
    chk("wb_valid", DW'(wb_valid), DW'(mwv));
    if (e_hit) chk("rd_data", rd_data, e_rdata);
    if (mwv) begin
      chk("wb_warp", DW'(wb_warp), DW'(mww));
      chk("wb_reg",  DW'(wb_reg),  DW'(mwr));
      chk("wb_data", wb_data, mwd);
    end
    @(posedge clk);
    model_seq();
    @(negedge clk);
    wr_valid = 0; rd_valid = 0; rd_last = 0; act_valid = 0; deact_valid = 0;
  endtask

  task automatic wr(int w, int r, int unsigned s);
    wr_valid = 1; wr_warp = 4'(w); wr_reg = 6'(r); wr_data = mk(s);
  endtask
  task automatic rd(int w, int r, bit last);
    rd_valid = 1; rd_warp = 4'(w); rd_reg = 6'(r); rd_last = last;
  endtask

  initial begin
    mwv = 0; mww = 0; mwr = 0; mwd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty, nothing enabled
    cur = "R1"; rd(0, 0, 0); cyc();
    // R6: disabled warp write bypasses, read misses
    cur = "R6"; wr(2, 1, 32'h11); cyc(); rd(2, 1, 0); cyc();
    // R2: allocate then hit
    cur = "R2"; act_valid = 1; act_warp = 1; cyc();
    wr(1, 3, 32'h33); cyc(); rd(1, 3, 0); cyc();
    // R3: overwrite in place
    cur = "R3"; wr(1, 3, 32'h34); cyc(); rd(1, 3, 0); cyc();
    // R4: fill and evict oldest (reg 3)
    cur = "R4";
    for (int k = 0; k < 7; k++) begin wr(1, 10 + k, 32'h100 + k); cyc(); end
    wr(1, 20, 32'h200); cyc(); cyc(); rd(1, 3, 0); cyc();
    // R5: last-use read then dead victim dropped
    cur = "R5"; rd(1, 10, 1); cyc(); wr(1, 21, 32'h210); cyc(); cyc();
    // R10: last-use read and write hit together, then evict it
    cur = "R10"; rd(1, 11, 1); wr(1, 11, 32'h111); cyc();
    wr(1, 22, 32'h220); cyc(); cyc();
    // R5 collision: last-use read of the victim while it is being evicted
    cur = "R5"; rd(1, 12, 1); wr(1, 23, 32'h230); cyc(); cyc();
    // R8: stalled writeback stream
    cur = "R8"; wb_ready = 0; wr(5, 0, 32'h500); cyc();
    for (int k = 0; k < 3; k++) begin wr(5, 1, 32'h501); cyc(); end
    wb_ready = 1; wr(5, 1, 32'h501); cyc(); cyc();
    // R7: drain two warps with back-pressure
    cur = "R7"; act_valid = 1; act_warp = 2; cyc();
    wr(2, 1, 32'h21); cyc(); wr(2, 2, 32'h22); cyc(); rd(2, 1, 1); cyc();
    deact_valid = 1; deact_warp = 1; wr(1, 5, 32'h15); cyc();
    deact_valid = 1; deact_warp = 2; cyc();
    for (int k = 0; k < 14; k++) begin
      wb_ready = k[0]; wr(1, 6, 32'h16); rd(2, 2, 0); cyc();
    end
    wb_ready = 1; cyc();
    // R9: enable and disable of one warp in one cycle
    cur = "R9"; act_valid = 1; act_warp = 3; deact_valid = 1; deact_warp = 3; cyc();
    wr(3, 4, 32'h34); cyc(); rd(3, 4, 0); cyc();
    act_valid = 1; act_warp = 3; rd(3, 4, 0); cyc();
    // R8 with random traffic over a small tag space
    cur = "R8";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) begin act_valid = 1; act_warp = 4'($urandom_range(3)); end
      if ($urandom_range(24) == 0) begin deact_valid = 1; deact_warp = 4'($urandom_range(3)); end
      if ($urandom_range(1) == 0) wr($urandom_range(3), $urandom_range(5), $urandom);
      if ($urandom_range(1) == 0) rd($urandom_range(3), $urandom_range(5), $urandom_range(3) == 0);
      wb_ready = ($urandom_range(3) != 0);
      cyc();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog %s run did not finish", cur);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule